// File: doc/BRIEF.md
# Task State Validation Checker

When a hardware task switch happens, the descriptors of the incoming task must be checked before execution can resume there. This block receives those descriptors already fetched. They are the task state segment descriptor, the local descriptor table descriptor, the code and stack segment descriptors, and the four data segment descriptors, each with its selector. The block runs sixteen ordered tests on them. The first test that fails determines the result: an exception class, the selector that goes into the error code, and the index of the failing test. When every test passes, the block raises a pass flag instead.

The surrounding switch sequencer presents all inputs and pulses `start_i` for one cycle. The verdict appears one cycle later, together with a one-cycle `valid_o`, and stays on the outputs until the next start. All evaluation between the input pins and the output registers is combinational.

Descriptor type fields are five bits wide, written {S, T3, T2, T1, T0}:
- S=1 marks a memory segment.
- T3=1 marks code.
- For code, T2 means conforming and T1 means readable.
- For data, T1 means writable.
- A local descriptor table descriptor has the type 5'b00010.

Top module: `tsv_checker`

## Requirements
- R1: `valid_o` is high in exactly the cycle after a cycle with `start_i` high, and low otherwise. `pass_o`, `exc_o`, `test_o` and `err_sel_o` change only on a start and hold their values between starts.
- R2: The tests are numbered 1 to 16, and `test_o` carries the test number minus one. The lowest-numbered failing test is reported. When no test fails, `pass_o` is 1 and `exc_o`, `test_o` and `err_sel_o` are all 0. Class encoding: 0 = segment not present, 1 = general protection, 2 = invalid task state, 3 = stack fault.
- R3: There are three task state descriptor tests, each reporting the task state selector:
  - test 1: the descriptor is not present (class 0);
  - test 2: the descriptor is busy (class 1);
  - test 3: the segment limit is below 103 (class 2). A limit of exactly 103 passes.
- R4: A selector is valid under four conditions:
  - it is not null, meaning bits 15:2 are not all zero;
  - its table is allowed, with bit 2 set choosing the local table;
  - index*8+7 does not exceed that table's limit;
  - the descriptor type matches the selector's use.
- R5: There are two local descriptor table tests, each with class 2 and each reporting the task state selector:
  - test 4: the selector is invalid. It must point into the global table and have the type 5'b00010.
  - test 5: the local table is not present.
- R6: There are three code segment tests, each reporting the CS selector:
  - test 6: the CS selector is invalid, where the type must be code (class 2);
  - test 7: the segment is not present (class 0);
  - test 8: the code DPL differs from the CS selector RPL (class 2).
- R7: There are four stack tests, each reporting the SS selector. CPL is bits 1:0 of the CS selector.
  - test 9: the SS selector is invalid, where the type must be writable data (class 1);
  - test 10: the stack is not present (class 3);
  - test 11: the stack DPL differs from CPL (class 3);
  - test 12: the SS selector RPL differs from CPL (class 1).
- R8: There are four data segment tests. Index 0..3 of the data segment ports is DS, ES, FS, GS.
  - test 13: the selector is invalid, where any S=1 type is accepted (class 1);
  - test 14: the segment is unreadable, meaning code with T1=0 (class 1);
  - test 15: the segment is not present (class 0);
  - test 16: DPL is below CPL and the segment is not conforming code (class 1).
  
  The lowest failing test number wins. Within that test, the first failing register in DS, ES, FS, GS order wins, and its selector is reported.
- R9: A null data selector excludes that register from tests 13 to 16, whatever its descriptor inputs are.
- R10: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Evaluate the presented descriptors |
| gdt_limit_i | input | 16 | Global table limit in bytes |
| ldt_limit_i | input | 16 | Local table limit in bytes |
| tss_sel_i | input | 16 | Incoming task state selector |
| tss_present_i | input | 1 | Task state descriptor present |
| tss_busy_i | input | 1 | Task state descriptor busy |
| tss_limit_i | input | TSS_LIM_W | Task state segment limit |
| ldt_sel_i | input | 16 | Local table selector |
| ldt_type_i | input | 5 | Local table descriptor type |
| ldt_present_i | input | 1 | Local table present |
| cs_sel_i | input | 16 | Code selector |
| cs_type_i | input | 5 | Code descriptor type |
| cs_present_i | input | 1 | Code segment present |
| cs_dpl_i | input | 2 | Code descriptor DPL |
| ss_sel_i | input | 16 | Stack selector |
| ss_type_i | input | 5 | Stack descriptor type |
| ss_present_i | input | 1 | Stack segment present |
| ss_dpl_i | input | 2 | Stack descriptor DPL |
| seg_sel_i | input | NUM_DATA x 16 | Data selectors (DS, ES, FS, GS) |
| seg_type_i | input | NUM_DATA x 5 | Data descriptor types |
| seg_present_i | input | NUM_DATA | Data segments present |
| seg_dpl_i | input | NUM_DATA x 2 | Data descriptor DPLs |
| valid_o | output | 1 | Verdict valid, one cycle after start |
| pass_o | output | 1 | All tests passed |
| exc_o | output | 2 | Exception class of the first failure |
| err_sel_o | output | 16 | Selector for the error code |
| test_o | output | 4 | Failing test number minus one |

## Verification
The hardest situations to reach are the ones where several faults overlap. One example is a data fault that sits in a later test but an earlier register, alongside an earlier-test fault in a later register. Another is a fault on a null data selector, which must stay invisible. The stimulus starts from a fully passing descriptor set and applies one or two directed mutations at a time. This covers every test, the exact limit and bound boundaries, and the register-order tie breaks. A long phase of random multi-field mutations then lets faults stack up in many combinations. A behavioural reference model checks every cycle of both phases.

// File: rtl/tsv_pkg.sv
package tsv_pkg;
  localparam int SEL_W = 16;
  localparam int TYPE_W = 5;
  localparam int NUM_TESTS = 16;

  typedef enum logic [1:0] {
    EXC_NP = 2'd0,
    EXC_GP = 2'd1,
    EXC_TS = 2'd2,
    EXC_SF = 2'd3
  } exc_e;

  typedef enum logic [1:0] {
    K_LDT,
    K_CODE,
    K_STACK,
    K_DATA
  } sel_kind_e;

  localparam logic [TYPE_W-1:0] LDT_TYPE = 5'b00010;

  function automatic exc_e test_class(logic [3:0] idx);
    case (idx)
      4'd0, 4'd6, 4'd14:               return EXC_NP;
      4'd2, 4'd3, 4'd4, 4'd5, 4'd7:    return EXC_TS;
      4'd9, 4'd10:                     return EXC_SF;
      default:                         return EXC_GP;
    endcase
  endfunction
endpackage

// File: rtl/tsv_prio.sv
module tsv_prio #(
  parameter int N = 16,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req_i,
  output logic [W-1:0] idx_o,
  output logic         any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = i[W-1:0];
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/tsv_sel_check.sv
module tsv_sel_check
  import tsv_pkg::*;
#(
  parameter sel_kind_e KIND = K_DATA
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic [15:0]       gdt_limit_i,
  input  logic [15:0]       ldt_limit_i,
  output logic              ok_o
);
  logic not_null, table_ok, in_bounds, type_ok;
  logic [15:0] last_byte;

  assign not_null  = |sel_i[SEL_W-1:2];
  assign last_byte = {sel_i[SEL_W-1:3], 3'b111};
  assign in_bounds = last_byte <= (sel_i[2] ? ldt_limit_i : gdt_limit_i);

  generate
    if (KIND == K_LDT) begin : g_ldt
      assign table_ok = ~sel_i[2];
      assign type_ok  = (type_i == LDT_TYPE);
    end else if (KIND == K_CODE) begin : g_code
      assign table_ok = 1'b1;
      assign type_ok  = type_i[4] & type_i[3];
    end else if (KIND == K_STACK) begin : g_stack
      assign table_ok = 1'b1;
      assign type_ok  = type_i[4] & ~type_i[3] & type_i[1];
    end else begin : g_data
      assign table_ok = 1'b1;
      assign type_ok  = type_i[4];
    end
  endgenerate

  assign ok_o = not_null & table_ok & in_bounds & type_ok;
endmodule

// File: rtl/tsv_data_tests.sv
module tsv_data_tests
  import tsv_pkg::*;
(
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic              present_i,
  input  logic [1:0]        dpl_i,
  input  logic [1:0]        cpl_i,
  input  logic [15:0]       gdt_limit_i,
  input  logic [15:0]       ldt_limit_i,
  output logic [3:0]        fail_o      // bit k = test 13+k
);
  logic sel_ok, is_null, readable, conforming;

  tsv_sel_check #(.KIND(K_DATA)) u_sel (
    .sel_i(sel_i), .type_i(type_i),
    .gdt_limit_i(gdt_limit_i), .ldt_limit_i(ldt_limit_i),
    .ok_o(sel_ok)
  );

  assign is_null    = ~|sel_i[SEL_W-1:2];
  assign readable   = ~type_i[3] | type_i[1];
  assign conforming = type_i[4] & type_i[3] & type_i[2];

  always_comb begin
    fail_o[0] = ~sel_ok;
    fail_o[1] = ~readable;
    fail_o[2] = ~present_i;
    fail_o[3] = ~conforming & (dpl_i < cpl_i);
    if (is_null) fail_o = '0;
  end
endmodule

// File: rtl/tsv_checker.sv
module tsv_checker
  import tsv_pkg::*;
#(
  parameter int TSS_LIM_W     = 20,
  parameter int MIN_TSS_LIMIT = 103,
  parameter int NUM_DATA      = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            start_i,
  input  logic [15:0]                     gdt_limit_i,
  input  logic [15:0]                     ldt_limit_i,
  input  logic [15:0]                     tss_sel_i,
  input  logic                            tss_present_i,
  input  logic                            tss_busy_i,
  input  logic [TSS_LIM_W-1:0]            tss_limit_i,
  input  logic [15:0]                     ldt_sel_i,
  input  logic [4:0]                      ldt_type_i,
  input  logic                            ldt_present_i,
  input  logic [15:0]                     cs_sel_i,
  input  logic [4:0]                      cs_type_i,
  input  logic                            cs_present_i,
  input  logic [1:0]                      cs_dpl_i,
  input  logic [15:0]                     ss_sel_i,
  input  logic [4:0]                      ss_type_i,
  input  logic                            ss_present_i,
  input  logic [1:0]                      ss_dpl_i,
  input  logic [NUM_DATA-1:0][15:0]       seg_sel_i,
  input  logic [NUM_DATA-1:0][4:0]        seg_type_i,
  input  logic [NUM_DATA-1:0]             seg_present_i,
  input  logic [NUM_DATA-1:0][1:0]        seg_dpl_i,
  output logic                            valid_o,
  output logic                            pass_o,
  output logic [1:0]                      exc_o,
  output logic [15:0]                     err_sel_o,
  output logic [3:0]                      test_o
);
  localparam int NT = NUM_TESTS;
  localparam int TW = $clog2(NT);
  localparam int DW = (NUM_DATA > 1) ? $clog2(NUM_DATA) : 1;

  logic [1:0] cpl;
  logic ldt_ok, cs_ok, ss_ok;
  logic [NUM_DATA-1:0][3:0] dfail;
  logic [3:0][DW-1:0] dpick;
  logic [3:0] dany;
  logic [NT-1:0] fails;
  logic [TW-1:0] first;
  logic any_fail;
  logic [15:0] err_sel_d;

  assign cpl = cs_sel_i[1:0];

  tsv_sel_check #(.KIND(K_LDT)) u_ldt_sel (
    .sel_i(ldt_sel_i), .type_i(ldt_type_i),
    .gdt_limit_i(gdt_limit_i), .ldt_limit_i(ldt_limit_i), .ok_o(ldt_ok)
  );
  tsv_sel_check #(.KIND(K_CODE)) u_cs_sel (
    .sel_i(cs_sel_i), .type_i(cs_type_i),
    .gdt_limit_i(gdt_limit_i), .ldt_limit_i(ldt_limit_i), .ok_o(cs_ok)
  );
  tsv_sel_check #(.KIND(K_STACK)) u_ss_sel (
    .sel_i(ss_sel_i), .type_i(ss_type_i),
    .gdt_limit_i(gdt_limit_i), .ldt_limit_i(ldt_limit_i), .ok_o(ss_ok)
  );

  generate
    for (genvar r = 0; r < NUM_DATA; r++) begin : g_data
      tsv_data_tests u_dt (
        .sel_i(seg_sel_i[r]), .type_i(seg_type_i[r]),
        .present_i(seg_present_i[r]), .dpl_i(seg_dpl_i[r]), .cpl_i(cpl),
        .gdt_limit_i(gdt_limit_i), .ldt_limit_i(ldt_limit_i),
        .fail_o(dfail[r])
      );
    end
    // per data test: pick first register in DS, ES, FS, GS order
    for (genvar j = 0; j < 4; j++) begin : g_pick
      logic [NUM_DATA-1:0] col;
      always_comb begin
        for (int r = 0; r < NUM_DATA; r++) col[r] = dfail[r][j];
      end
      tsv_prio #(.N(NUM_DATA)) u_prio (.req_i(col), .idx_o(dpick[j]), .any_o(dany[j]));
    end
  endgenerate

  always_comb begin
    fails[0]  = ~tss_present_i;
    fails[1]  = tss_busy_i;
    fails[2]  = tss_limit_i < TSS_LIM_W'(MIN_TSS_LIMIT);
    fails[3]  = ~ldt_ok;
    fails[4]  = ~ldt_present_i;
    fails[5]  = ~cs_ok;
    fails[6]  = ~cs_present_i;
    fails[7]  = cs_dpl_i != cs_sel_i[1:0];
    fails[8]  = ~ss_ok;
    fails[9]  = ~ss_present_i;
    fails[10] = ss_dpl_i != cpl;
    fails[11] = ss_sel_i[1:0] != cpl;
    fails[15:12] = dany;
  end

  tsv_prio #(.N(NT)) u_first (.req_i(fails), .idx_o(first), .any_o(any_fail));

  always_comb begin
    if (first <= TW'(4))      err_sel_d = tss_sel_i;
    else if (first <= TW'(7)) err_sel_d = cs_sel_i;
    else if (first <= TW'(11)) err_sel_d = ss_sel_i;
    else                      err_sel_d = seg_sel_i[dpick[first[1:0]]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      pass_o    <= 1'b0;
      exc_o     <= 2'd0;
      err_sel_o <= '0;
      test_o    <= '0;
    end else begin
      valid_o <= start_i;
      if (start_i) begin
        pass_o    <= ~any_fail;
        exc_o     <= any_fail ? test_class(first) : 2'd0;
        err_sel_o <= any_fail ? err_sel_d : '0;
        test_o    <= any_fail ? first : '0;
      end
    end
  end
endmodule

// File: rtl/tsv_checker_sva.sv
module tsv_checker_sva (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [15:0] tss_sel_i,
  input logic        tss_present_i,
  input logic        tss_busy_i,
  input logic        valid_o,
  input logic        pass_o,
  input logic [1:0]  exc_o,
  input logic [15:0] err_sel_o,
  input logic [3:0]  test_o
);
  // R1
  valid_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);
  // R1
  no_valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o);
  // R1
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(pass_o) && $stable(exc_o) && $stable(test_o) && $stable(err_sel_o));
  // R2
  pass_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> exc_o == 2'd0 && test_o == 4'd0 && err_sel_o == 16'd0);
  // R3
  absent_tss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !tss_present_i |=>
      !pass_o && test_o == 4'd0 && exc_o == 2'd0 && err_sel_o == $past(tss_sel_i));
  // R3
  busy_tss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && tss_present_i && tss_busy_i |=>
      !pass_o && test_o == 4'd1 && exc_o == 2'd1);
  // R10
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !valid_o && !pass_o);
endmodule

bind tsv_checker tsv_checker_sva u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .tss_sel_i(tss_sel_i), .tss_present_i(tss_present_i), .tss_busy_i(tss_busy_i),
  .valid_o(valid_o), .pass_o(pass_o), .exc_o(exc_o),
  .err_sel_o(err_sel_o), .test_o(test_o)
);

// File: tb/tsv_checker_test.sv
module tsv_checker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] gdt_lim, ldt_lim, tss_sel, ldt_sel, cs_sel, ss_sel;
  logic tss_p, tss_b, ldt_p, cs_p, ss_p;
  logic [19:0] tss_lim;
  logic [4:0] ldt_ty, cs_ty, ss_ty;
  logic [1:0] cs_dpl, ss_dpl;
  logic [3:0][15:0] seg_sel;
  logic [3:0][4:0] seg_ty;
  logic [3:0] seg_p;
  logic [3:0][1:0] seg_dpl;
  logic valid, pass;
  logic [1:0] exc;
  logic [15:0] esel;
  logic [3:0] tst;

  int checks = 0, failures = 0;
  bit exp_valid = 0, exp_pass = 0;
  int exp_exc = 0, exp_tst = 0, exp_sel = 0;
  string tag = "R10";

  always #2.5 clk = ~clk;

  tsv_checker uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .gdt_limit_i(gdt_lim), .ldt_limit_i(ldt_lim),
    .tss_sel_i(tss_sel), .tss_present_i(tss_p), .tss_busy_i(tss_b), .tss_limit_i(tss_lim),
    .ldt_sel_i(ldt_sel), .ldt_type_i(ldt_ty), .ldt_present_i(ldt_p),
    .cs_sel_i(cs_sel), .cs_type_i(cs_ty), .cs_present_i(cs_p), .cs_dpl_i(cs_dpl),
    .ss_sel_i(ss_sel), .ss_type_i(ss_ty), .ss_present_i(ss_p), .ss_dpl_i(ss_dpl),
    .seg_sel_i(seg_sel), .seg_type_i(seg_ty), .seg_present_i(seg_p), .seg_dpl_i(seg_dpl),
    .valid_o(valid), .pass_o(pass), .exc_o(exc), .err_sel_o(esel), .test_o(tst)
  );

  // kind: 0 local table, 1 code, 2 stack, 3 data
  function automatic bit sel_ok(logic [15:0] s, int kind, logic [4:0] ty);
    int idx = int'(s) / 8;
    int lim = s[2] ? int'(ldt_lim) : int'(gdt_lim);
    if ((s & 16'hFFFC) == 0) return 0;
    if (kind == 0 && s[2]) return 0;
    if (idx * 8 + 7 > lim) return 0;
    case (kind)
      0: return ty == 5'b00010;
      1: return ty[4] && ty[3];
      2: return ty[4] && !ty[3] && ty[1];
      default: return ty[4];
    endcase
  endfunction

  task automatic model(output bit ps, output int cl, output int tn, output int sl);
    int cpl = int'(cs_sel[1:0]);
    bit f [1:16];
    int cls [1:16] = '{0, 1, 2, 2, 2, 2, 0, 2, 1, 3, 3, 1, 1, 1, 0, 1};
    int sels [1:16];
    f[1] = !tss_p;  f[2] = tss_b;  f[3] = tss_lim < 103;
    f[4] = !sel_ok(ldt_sel, 0, ldt_ty);  f[5] = !ldt_p;
    f[6] = !sel_ok(cs_sel, 1, cs_ty);  f[7] = !cs_p;  f[8] = int'(cs_dpl) != cpl;
    f[9] = !sel_ok(ss_sel, 2, ss_ty);  f[10] = !ss_p;
    f[11] = int'(ss_dpl) != cpl;  f[12] = int'(ss_sel[1:0]) != cpl;
    for (int t = 1; t <= 12; t++) sels[t] = (t <= 5) ? int'(tss_sel) : (t <= 8) ? int'(cs_sel) : int'(ss_sel);
    for (int t = 13; t <= 16; t++) begin
      f[t] = 0; sels[t] = 0;
      for (int r = 0; r < 4; r++) begin
        bit bad;
        if ((seg_sel[r] & 16'hFFFC) == 0) continue;
        case (t)
          13: bad = !sel_ok(seg_sel[r], 3, seg_ty[r]);
          14: bad = seg_ty[r][3] && !seg_ty[r][1];
          15: bad = !seg_p[r];
          default: bad = !(seg_ty[r][4] && seg_ty[r][3] && seg_ty[r][2]) && int'(seg_dpl[r]) < cpl;
        endcase
        if (bad && !f[t]) begin f[t] = 1; sels[t] = int'(seg_sel[r]); end
      end
    end
    ps = 1; cl = 0; tn = 0; sl = 0;
    for (int t = 16; t >= 1; t--) if (f[t]) begin ps = 0; cl = cls[t]; tn = t - 1; sl = sels[t]; end
  endtask

  task automatic chk(string what, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic step();
    if (rst_n) begin
      exp_valid = start;
      if (start) begin
        bit p; int c, t, s;
        model(p, c, t, s);
        exp_pass = p; exp_exc = c; exp_tst = t; exp_sel = s;
      end
    end
    @(negedge clk);
    chk("valid (R1)", int'(valid), int'(exp_valid));
    chk("pass", int'(pass), int'(exp_pass));
    chk("class", int'(exc), exp_exc);
    chk("test", int'(tst), exp_tst);
    chk("selector", int'(esel), exp_sel);
  endtask

  task automatic run(string t);
    tag = t;
    start = 1'b1; step();
    start = 1'b0; step();
  endtask

  task automatic base();
    gdt_lim = 16'h00FF; ldt_lim = 16'h003F;
    tss_sel = 16'h0028; tss_p = 1; tss_b = 0; tss_lim = 20'd103;
    ldt_sel = 16'h0030; ldt_ty = 5'b00010; ldt_p = 1;
    cs_sel = 16'h001B; cs_ty = 5'b11010; cs_p = 1; cs_dpl = 2'd3;
    ss_sel = 16'h0023; ss_ty = 5'b10010; ss_p = 1; ss_dpl = 2'd3;
    seg_sel = {16'h0000, 16'h000F, 16'h0023, 16'h0023};
    seg_ty = {4{5'b10010}}; seg_p = 4'hF; seg_dpl = {4{2'd3}};
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    base();
    @(negedge clk); @(negedge clk);
    tag = "R10"; step();
    rst_n = 1'b1;
    tag = "R10"; step();

    base(); run("R2");
    base(); tss_p = 0; run("R3");
    base(); tss_p = 0; tss_b = 1; run("R2");
    base(); tss_b = 1; run("R3");
    base(); tss_lim = 20'd102; run("R3");
    base(); tss_lim = 20'd103; run("R3");
    base(); ldt_sel = 16'h0034; run("R5");
    base(); ldt_ty = 5'b00011; run("R5");
    base(); ldt_p = 0; run("R5");
    base(); ldt_sel = 16'h0000; run("R5");
    base(); cs_sel = 16'h0103; cs_dpl = 2'd3; run("R4");
    base(); cs_sel = 16'h00FB; run("R4");
    base(); cs_sel = 16'h003F; run("R4");
    base(); cs_ty = 5'b10010; run("R6");
    base(); cs_p = 0; run("R6");
    base(); cs_dpl = 2'd2; run("R6");
    base(); ss_ty = 5'b10000; run("R7");
    base(); ss_p = 0; run("R7");
    base(); ss_dpl = 2'd2; run("R7");
    base(); ss_sel = 16'h0022; run("R7");
    base(); seg_ty[1] = 5'b00010; run("R8");
    base(); seg_ty[0] = 5'b11000; run("R8");
    base(); seg_p[2] = 0; run("R8");
    base(); seg_dpl[0] = 2'd2; run("R8");
    base(); seg_ty[0] = 5'b11110; seg_dpl[0] = 2'd0; run("R8");
    base(); seg_p[0] = 0; seg_ty[2] = 5'b00000; run("R8");
    base(); seg_ty[1] = 5'b00000; seg_ty[2] = 5'b00000; run("R8");
    base(); seg_p[3] = 0; seg_ty[3] = 5'b00000; run("R9");
    base(); seg_sel[0] = 16'h0003; seg_ty[0] = 5'b00000; seg_p[0] = 0; run("R9");
    base(); cs_p = 0; tss_lim = 20'd50; run("R2");
    base(); tag = "R1"; step(); step();

    for (int i = 0; i < 400; i++) begin
      base();
      if ($urandom_range(0, 15) == 0) tss_p = 0;
      if ($urandom_range(0, 15) == 0) tss_b = 1;
      if ($urandom_range(0, 7) == 0) tss_lim = 20'($urandom_range(96, 110));
      if ($urandom_range(0, 7) == 0) ldt_sel = 16'($urandom_range(0, 511));
      if ($urandom_range(0, 15) == 0) ldt_p = 0;
      if ($urandom_range(0, 3) == 0) cs_sel = 16'($urandom_range(0, 300));
      if ($urandom_range(0, 7) == 0) cs_ty = 5'($urandom);
      if ($urandom_range(0, 7) == 0) cs_dpl = 2'($urandom);
      if ($urandom_range(0, 15) == 0) cs_p = 0;
      if ($urandom_range(0, 3) == 0) ss_sel = 16'($urandom_range(0, 300));
      if ($urandom_range(0, 7) == 0) ss_ty = 5'($urandom);
      if ($urandom_range(0, 7) == 0) ss_dpl = 2'($urandom);
      if ($urandom_range(0, 15) == 0) ss_p = 0;
      for (int r = 0; r < 4; r++) begin
        if ($urandom_range(0, 3) == 0) seg_sel[r] = 16'($urandom_range(0, 300));
        if ($urandom_range(0, 3) == 0) seg_ty[r] = 5'($urandom);
        if ($urandom_range(0, 7) == 0) seg_p[r] = 0;
        if ($urandom_range(0, 3) == 0) seg_dpl[r] = 2'($urandom);
      end
      tag = "R2";
      start = 1'b1; step();
      start = 1'($urandom_range(0, 1)); step();
      start = 1'b0;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule